// File: doc/BRIEF.md
# Processor Mode and Status-Flag Unit

This unit keeps the eight-bit processor status register and the hidden emulation bit of a 16-bit processor core that can fall back to an 8-bit compatible mode. The instruction decoder hands it one operation at a time, through a valid strobe, an operation code and an eight-bit operand. The operand is an immediate mask for the bit-clear and bit-set operations, or a status byte pulled from the stack for an interrupt return. The unit updates the status and the emulation bit in the same clock edge.

The unit also keeps the mode coupling rules. While the emulation bit is 1, both width flags read as 1. The unit tells the register file when the stack pointer high byte must be forced to the page value, and when the index high bytes must be cleared. It also gives the interrupt controller and the decoder one-cycle pulses when they must re-evaluate. Status layout, bit 7 down to bit 0: N, V, M, X, D, I, Z, C. So C is bit 0, Z bit 1, I bit 2, D bit 3, X (index width) bit 4, M (memory width) bit 5, V bit 6 and N bit 7.

Top module: `sfu_status_unit`

## Requirements
- R1: During synchronous active-low reset, status becomes 0x34 (M, X and I set) and emu becomes 1. idx_hi_clr, sp_hi_force, irq_recheck and width_chg are all 0.
- R2: op_code 1 (exchange) swaps C and emu at one clock edge. The new emu is the old C, and the new C is the old emu.
- R3: Whenever emu is 1 after an operation, status bits 5 (M) and 4 (X) are 1, whatever the operation wrote.
- R4: After op_code 1 or op_code 5 (stack-pointer load) leaves emu at 1, sp_hi_force pulses in the next cycle if sp_hi was not 0x01 when the operation was accepted.
- R5: After any accepted operation that leaves X at 1, idx_hi_clr pulses in the next cycle if x_hi or y_hi was nonzero.
- R6: op_code 2 clears every status bit whose op_data bit is 1, and leaves the other bits unchanged (subject to R3).
- R7: op_code 3 sets every status bit whose op_data bit is 1, and leaves the other bits unchanged.
- R8: op_code 4 (interrupt return) loads status from op_data (subject to R3), and emu is unchanged.
- R9: irq_recheck pulses in the cycle after an accepted op_code 2 or op_code 4, and never after op_code 3.
- R10: width_chg pulses in the cycle after an operation that changes M or X.
- R11: When op_valid is 0, or op_code is 0, 6 or 7, status and emu hold and no pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe from the decoder |
| op_code | input | 3 | 1 exchange, 2 clear bits, 3 set bits, 4 interrupt return, 5 stack-pointer load |
| op_data | input | 8 | Mask or pulled status byte |
| x_hi | input | 8 | Current high byte of X index register |
| y_hi | input | 8 | Current high byte of Y index register |
| sp_hi | input | 8 | Current high byte of stack pointer |
| status | output | 8 | Status register N V M X D I Z C |
| emu | output | 1 | Emulation bit |
| idx_hi_clr | output | 1 | Pulse: clear both index high bytes |
| sp_hi_force | output | 1 | Pulse: force stack high byte to 0x01 |
| irq_recheck | output | 1 | Pulse: re-examine pending maskable interrupt |
| width_chg | output | 1 | Pulse: operand widths changed |

## Verification
An exchange that enters emulation from native mode, with the index width clear, does several things at one edge. It forces the width flags, which raises width_chg. It raises sp_hi_force, and because X is now 1 it also raises idx_hi_clr. The stimulus table provokes this case with nonzero index high bytes and a stack high byte that is not 0x01. All four pulses and the forced status are judged in the one cycle after the edge. A clear-bits operation that tries to drop the widths while in emulation gives a second overlap: irq_recheck must pulse, and the status must keep M and X.

// File: rtl/sfu_pkg.sv
// Package: shared operation codes and status bit positions for the
// status-flag unit. Assumes the fixed layout N V M X D I Z C.
package sfu_pkg;
    localparam int unsigned ST_W   = 8;
    localparam int unsigned BIT_C  = 0;
    localparam int unsigned BIT_Z  = 1;
    localparam int unsigned BIT_I  = 2;
    localparam int unsigned BIT_D  = 3;
    localparam int unsigned BIT_X  = 4;
    localparam int unsigned BIT_M  = 5;
    localparam int unsigned BIT_V  = 6;
    localparam int unsigned BIT_N  = 7;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_XCHG    = 3'd1,
        OP_CLR     = 3'd2,
        OP_SET     = 3'd3,
        OP_RESTORE = 3'd4,
        OP_SPLOAD  = 3'd5
    } sfu_op_e;

    typedef struct packed {
        logic idx_clr;
        logic sp_force;
        logic recheck;
        logic wchg;
    } sfu_evt_t;
endpackage

// File: rtl/sfu_flag_alu.sv
// Module: raw next-state logic for status and emulation bit.
// Computes what each operation writes before mode coupling is applied.
// Assumes op_code values from sfu_pkg; unknown codes hold the state.
module sfu_flag_alu
    import sfu_pkg::*;
#(
    parameter int unsigned W = ST_W
) (
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] op_data,
    input  logic [W-1:0] cur_st,
    input  logic         cur_emu,
    output logic [W-1:0] raw_st,
    output logic         raw_emu,
    output logic         accepted
);
    logic is_xchg, is_clr, is_set, is_rest, is_spld;

    // Decode the operation class once for all bit slices.
    always_comb begin
        is_xchg = op_valid && (op_code == OP_XCHG);
        is_clr  = op_valid && (op_code == OP_CLR);
        is_set  = op_valid && (op_code == OP_SET);
        is_rest = op_valid && (op_code == OP_RESTORE);
        is_spld = op_valid && (op_code == OP_SPLOAD);
        accepted = is_xchg || is_clr || is_set || is_rest || is_spld;
    end

    // One slice per status bit; the carry slice also takes the exchange.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == BIT_C) begin : g_carry
            // Carry slice: exchange takes the old emulation bit.
            always_comb begin
                if (is_xchg)      raw_st[i] = cur_emu;
                else if (is_clr)  raw_st[i] = cur_st[i] & ~op_data[i];
                else if (is_set)  raw_st[i] = cur_st[i] | op_data[i];
                else if (is_rest) raw_st[i] = op_data[i];
                else              raw_st[i] = cur_st[i];
            end
        end else begin : g_plain
            // Ordinary slice: mask clear, mask set or load.
            always_comb begin
                if (is_clr)       raw_st[i] = cur_st[i] & ~op_data[i];
                else if (is_set)  raw_st[i] = cur_st[i] | op_data[i];
                else if (is_rest) raw_st[i] = op_data[i];
                else              raw_st[i] = cur_st[i];
            end
        end
    end

    // Exchange moves the old carry into the emulation bit.
    always_comb begin
        raw_emu = is_xchg ? cur_st[BIT_C] : cur_emu;
    end
endmodule

// File: rtl/sfu_mode_couple.sv
// Module: applies mode coupling to the raw next state and works out the
// side-effect requests. Assumes the high-byte inputs are valid in the
// cycle the operation is accepted.
module sfu_mode_couple
    import sfu_pkg::*;
#(
    parameter int unsigned W       = ST_W,
    parameter int unsigned HB_W    = 8,
    parameter logic [7:0]  SP_PAGE = 8'h01
) (
    input  logic            accepted,
    input  logic [2:0]      op_code,
    input  logic [W-1:0]    cur_st,
    input  logic [W-1:0]    raw_st,
    input  logic            raw_emu,
    input  logic [HB_W-1:0] x_hi,
    input  logic [HB_W-1:0] y_hi,
    input  logic [HB_W-1:0] sp_hi,
    output logic [W-1:0]    next_st,
    output logic            next_emu,
    output sfu_evt_t        evt_d
);
    localparam logic [W-1:0] WIDTH_MASK = (W'(1) << BIT_M) | (W'(1) << BIT_X);

    logic sp_touch;

    // Emulation forces both width flags on top of what was written.
    always_comb begin
        next_emu = raw_emu;
        next_st  = raw_emu ? (raw_st | WIDTH_MASK) : raw_st;
    end

    // Side-effect requests, evaluated on the coupled next state.
    always_comb begin
        sp_touch       = (op_code == OP_XCHG) || (op_code == OP_SPLOAD);
        evt_d.idx_clr  = accepted && next_st[BIT_X] && ((x_hi | y_hi) != '0);
        evt_d.sp_force = accepted && sp_touch && next_emu && (sp_hi != HB_W'(SP_PAGE));
        evt_d.recheck  = accepted && ((op_code == OP_CLR) || (op_code == OP_RESTORE));
        evt_d.wchg     = accepted && ((next_st & WIDTH_MASK) != (cur_st & WIDTH_MASK));
    end
endmodule

// File: rtl/sfu_event_reg.sv
// Module: registers the side-effect requests into one-cycle pulses.
// Assumes requests are only raised in cycles with an accepted operation.
module sfu_event_reg
    import sfu_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  sfu_evt_t evt_d,
    output sfu_evt_t evt_q
);
    // Pulse register; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_d;
    end
endmodule

// File: rtl/sfu_status_unit.sv
// Module: top of the status-flag unit. Holds the status byte and the
// emulation bit, and exposes the coupled side-effect pulses one cycle
// after the operation. Assumes one operation per cycle at most.
module sfu_status_unit
    import sfu_pkg::*;
#(
    parameter int unsigned W        = ST_W,
    parameter int unsigned HB_W     = 8,
    parameter logic [7:0]  SP_PAGE  = 8'h01,
    parameter logic [7:0]  RST_STAT = 8'h34
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [W-1:0]    op_data,
    input  logic [HB_W-1:0] x_hi,
    input  logic [HB_W-1:0] y_hi,
    input  logic [HB_W-1:0] sp_hi,
    output logic [W-1:0]    status,
    output logic            emu,
    output logic            idx_hi_clr,
    output logic            sp_hi_force,
    output logic            irq_recheck,
    output logic            width_chg
);
    logic [W-1:0] st_q, raw_st, next_st;
    logic         emu_q, raw_emu, next_emu, accepted;
    sfu_evt_t     evt_d, evt_q;

    sfu_flag_alu #(.W(W)) u_alu (
        .op_valid (op_valid),
        .op_code  (op_code),
        .op_data  (op_data),
        .cur_st   (st_q),
        .cur_emu  (emu_q),
        .raw_st   (raw_st),
        .raw_emu  (raw_emu),
        .accepted (accepted)
    );

    sfu_mode_couple #(.W(W), .HB_W(HB_W), .SP_PAGE(SP_PAGE)) u_couple (
        .accepted (accepted),
        .op_code  (op_code),
        .cur_st   (st_q),
        .raw_st   (raw_st),
        .raw_emu  (raw_emu),
        .x_hi     (x_hi),
        .y_hi     (y_hi),
        .sp_hi    (sp_hi),
        .next_st  (next_st),
        .next_emu (next_emu),
        .evt_d    (evt_d)
    );

    sfu_event_reg u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_d (evt_d),
        .evt_q (evt_q)
    );

    // Architectural state: status byte and emulation bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= W'(RST_STAT);
            emu_q <= 1'b1;
        end else if (accepted) begin
            st_q  <= next_st;
            emu_q <= next_emu;
        end
    end

    // Drive the outputs from the registered state and pulses.
    always_comb begin
        status      = st_q;
        emu         = emu_q;
        idx_hi_clr  = evt_q.idx_clr;
        sp_hi_force = evt_q.sp_force;
        irq_recheck = evt_q.recheck;
        width_chg   = evt_q.wchg;
    end
endmodule

// File: rtl/sfu_status_unit_chk.sv
// Module: property checker bound to the status-flag unit.
module sfu_status_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [2:0] op_code,
    input logic [7:0] op_data,
    input logic [7:0] status,
    input logic       emu,
    input logic       idx_hi_clr,
    input logic       sp_hi_force,
    input logic       irq_recheck,
    input logic       width_chg
);
    p_xchg_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd1) |=> (emu == $past(status[0]) && status[0] == $past(emu)));

    p_emu_widths_r3: assert property (@(posedge clk) disable iff (!rst_n)
        emu |-> (status[5] && status[4]));

    p_sp_force_emu_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sp_hi_force |-> emu);

    p_idx_clr_xw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        idx_hi_clr |-> status[4]);

    p_recheck_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 3'd2 || op_code == 3'd4)) |=> irq_recheck);

    p_no_recheck_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd3) |=> !irq_recheck);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid) |=> ($stable(status) && $stable(emu) && !width_chg && !irq_recheck));

    p_set_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 3'd3) |=> ((status & $past(op_data)) == $past(op_data)));
endmodule

bind sfu_status_unit sfu_status_unit_chk u_chk (.*);

// File: tb/sfu_status_unit_tb.sv
module sfu_status_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [2:0] op_code = 3'd0;
    logic [7:0] op_data = 8'h00;
    logic [7:0] x_hi = 8'h00, y_hi = 8'h00, sp_hi = 8'h01;
    logic [7:0] status;
    logic       emu, idx_hi_clr, sp_hi_force, irq_recheck, width_chg;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    sfu_status_unit u_dut (.*);

    // Row: {op, data, x nonzero, sp bad, exp status, exp emu, pulses {idx,sp,rchk,wchg}}
    localparam int NROW = 15;
    localparam logic [25:0] VEC [NROW] = '{
        {3'd1, 8'h00, 1'b1, 1'b1, 8'h35, 1'b0, 4'b1000}, // R2 leave emulation
        {3'd2, 8'h30, 1'b1, 1'b0, 8'h05, 1'b0, 4'b0011}, // R6 R9 R10
        {3'd3, 8'h10, 1'b1, 1'b0, 8'h15, 1'b0, 4'b1001}, // R7 R5
        {3'd3, 8'hC2, 1'b0, 1'b0, 8'hD7, 1'b0, 4'b0000}, // R7
        {3'd2, 8'hC7, 1'b0, 1'b0, 8'h10, 1'b0, 4'b0010}, // R6
        {3'd4, 8'hA5, 1'b1, 1'b0, 8'hA5, 1'b0, 4'b0011}, // R8 R10
        {3'd5, 8'h00, 1'b1, 1'b1, 8'hA5, 1'b0, 4'b0000}, // R4 native
        {3'd1, 8'h00, 1'b1, 1'b1, 8'hB4, 1'b1, 4'b1101}, // R2 R3 R4 R5 overlap
        {3'd2, 8'h30, 1'b0, 1'b0, 8'hB4, 1'b1, 4'b0010}, // R3 R9
        {3'd4, 8'h00, 1'b0, 1'b0, 8'h30, 1'b1, 4'b0010}, // R8 R3
        {3'd5, 8'h00, 1'b0, 1'b0, 8'h30, 1'b1, 4'b0000}, // R4 sp ok
        {3'd5, 8'h00, 1'b0, 1'b1, 8'h30, 1'b1, 4'b0100}, // R4
        {3'd0, 8'hFF, 1'b1, 1'b1, 8'h30, 1'b1, 4'b0000}, // R11 code 0
        {3'd6, 8'hFF, 1'b1, 1'b1, 8'h30, 1'b1, 4'b0000}, // R11 code 6
        {3'd1, 8'h00, 1'b1, 1'b1, 8'h31, 1'b0, 4'b1000}  // R2 back to native
    };

    task automatic check(input string req, input logic [7:0] st_e, input logic emu_e,
                         input logic [3:0] p_e);
        logic [3:0] p_a;
        p_a = {idx_hi_clr, sp_hi_force, irq_recheck, width_chg};
        n_chk++;
        if (status !== st_e || emu !== emu_e || p_a !== p_e) begin
            n_bad++;
            $display("FAIL %s: status=%h emu=%b pulses=%b expected status=%h emu=%b pulses=%b",
                     req, status, emu, p_a, st_e, emu_e, p_e);
        end
    endtask

    task automatic apply(input logic v, input logic [2:0] op, input logic [7:0] d,
                         input logic xnz, input logic spbad);
        op_valid = v;
        op_code  = op;
        op_data  = d;
        x_hi     = xnz ? 8'h12 : 8'h00;
        y_hi     = 8'h00;
        sp_hi    = spbad ? 8'h00 : 8'h01;
        @(posedge clk);
        #1 op_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 reset", 8'h34, 1'b1, 4'b0000);
        rst_n = 1'b1;
        for (int i = 0; i < NROW; i++) begin
            apply(1'b1, VEC[i][25:23], VEC[i][22:15], VEC[i][14], VEC[i][13]);
            check($sformatf("row %0d R2-table", i), VEC[i][12:5], VEC[i][4], VEC[i][3:0]);
        end
        // R11: strobe low, clear-all mask must do nothing
        apply(1'b0, 3'd2, 8'hFF, 1'b1, 1'b1);
        check("R11 idle", 8'h31, 1'b0, 4'b0000);
        // R5: X set with only Y high byte nonzero
        op_valid = 1'b1; op_code = 3'd3; op_data = 8'h00; x_hi = 8'h00; y_hi = 8'h80; sp_hi = 8'h01;
        @(posedge clk); #1 op_valid = 1'b0;
        check("R5 y only", 8'h31, 1'b0, 4'b1000);
        // R6: clearing zero mask changes nothing but still rechecks
        apply(1'b1, 3'd2, 8'h00, 1'b0, 1'b0);
        check("R6 empty mask", 8'h31, 1'b0, 4'b0010);
        // R1: reset mid-run restores reset state and kills pulses
        apply(1'b1, 3'd2, 8'hFF, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 mid-run reset", 8'h34, 1'b1, 4'b0000);
        rst_n = 1'b1;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1: actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule